// File: doc/BRIEF.md
# Branch Condition Evaluator

This purely combinational unit settles two things for a relative branch in a processor's execute stage. First, whether the branch is taken. A 4-bit selector picks one of sixteen conditions, and the condition is tested against the negative, zero, overflow and carry flags of an 8-bit flag register. Second, the destination address. It adds a sign-extended displacement to the address of the following instruction. The displacement is 8 bits wide for a short branch and 16 bits wide for a long one.

The sixteen conditions come in complementary pairs: an even selector and the odd selector above it always give opposite answers. The set covers unsigned magnitude tests (built from carry and zero) and signed magnitude tests (built from negative xor overflow, combined with zero). The destination is produced on every input combination, whether or not the branch is taken. This includes the "never" condition, which still consumes its displacement.

Top module: `branch_eval`

## Requirements
- R1: Within `flags_i`, N is bit 3, Z is bit 2, V is bit 1 and C is bit 0. Bits 7 to 4 have no effect on `taken_o` or `target_o`.
- R2: Selector 0 (always) drives `taken_o`=1 and selector 1 (never) drives `taken_o`=0, for every flag value.
- R3: Selector 2 (higher) is taken when C=0 and Z=0. Selector 3 (lower or same) is taken when C=1 or Z=1.
- R4: Selector 4 (carry clear, higher or same) is taken when C=0. Selector 5 (carry set, lower) is taken when C=1.
- R5: Selector 6 (not equal) is taken when Z=0. Selector 7 (equal) is taken when Z=1.
- R6: Selectors 8/9 test V=0 and V=1. Selectors 10/11 test N=0 and N=1.
- R7: Selector 12 (signed greater or equal) is taken when N xor V = 0. Selector 13 (signed less than) is taken when N xor V = 1.
- R8: Selector 14 (signed greater than) is taken when Z=0 and N xor V = 0. Selector 15 (signed less or equal) is taken when Z=1 or N xor V = 1.
- R9: With `long_i`=0, `target_o` equals `pc_next_i` plus `offset_i[7:0]` sign-extended to 16 bits, modulo 2^16. In this mode `offset_i[15:8]` has no effect.
- R10: With `long_i`=1, `target_o` equals `pc_next_i` plus `offset_i` taken as a signed 16-bit value, modulo 2^16.
- R11: `target_o` depends only on `pc_next_i`, `offset_i` and `long_i`, and never on the selector or the flags. A never-taken branch still yields its full destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_sel_i | input | 4 | Condition selector, encoding as in R2 to R8 |
| flags_i | input | 8 | Flag register; N, Z, V, C in bits 3..0 |
| long_i | input | 1 | 1 selects the 16-bit displacement, 0 the 8-bit one |
| pc_next_i | input | 16 | Address of the instruction after the branch |
| offset_i | input | 16 | Displacement; only bits 7..0 are used in short mode |
| taken_o | output | 1 | Branch decision |
| target_o | output | 16 | Branch destination address |

## Verification
The decision and the destination are formed in the same evaluation from unrelated inputs. The bench therefore applies every selector against every flag nibble while the displacement, mode and PC change alongside. One scoreboard entry holds both expected outputs for that input vector, and the entry is judged half a clock period after the drive. The two functions meet directly when the "never" condition is combined with large long displacements and with PC values that wrap past 0xFFFF. In those cases the decision must read 0 while the wrapped destination is still exact. Junk in the upper flag nibble and in the upper displacement byte during short mode must not change either output.

// File: rtl/bce_pkg.sv
package bce_pkg;

  localparam int unsigned FLAG_W  = 8;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned PAIRS   = 1 << (SEL_W - 1);

  // bit positions of the tested flags inside the flag register
  localparam int unsigned POS_N = 3;
  localparam int unsigned POS_Z = 2;
  localparam int unsigned POS_V = 1;
  localparam int unsigned POS_C = 0;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } tflags_t;

  // pair index = selector >> 1; the odd member of a pair is the inverse
  typedef enum logic [SEL_W-2:0] {
    PR_ALWAYS = 3'd0,
    PR_HI     = 3'd1,
    PR_CARRYC = 3'd2,
    PR_NEQ    = 3'd3,
    PR_OVFC   = 3'd4,
    PR_PLUS   = 3'd5,
    PR_SGE    = 3'd6,
    PR_SGT    = 3'd7
  } pair_e;

  function automatic tflags_t unpack_flags(input logic [FLAG_W-1:0] raw);
    tflags_t f;
    f.n = raw[POS_N];
    f.z = raw[POS_Z];
    f.v = raw[POS_V];
    f.c = raw[POS_C];
    return f;
  endfunction

endpackage

// File: rtl/bce_pred_vec.sv
module bce_pred_vec
  import bce_pkg::*;
(
  input  tflags_t            flags_i,
  output logic [PAIRS-1:0]   base_o
);

  logic sgn_lt;

  always_comb begin
    sgn_lt = flags_i.n ^ flags_i.v;
    base_o = '0;
    base_o[PR_ALWAYS] = 1'b1;
    base_o[PR_HI]     = ~(flags_i.c | flags_i.z);
    base_o[PR_CARRYC] = ~flags_i.c;
    base_o[PR_NEQ]    = ~flags_i.z;
    base_o[PR_OVFC]   = ~flags_i.v;
    base_o[PR_PLUS]   = ~flags_i.n;
    base_o[PR_SGE]    = ~sgn_lt;
    base_o[PR_SGT]    = ~(flags_i.z | sgn_lt);
  end

endmodule

// File: rtl/bce_cond_pick.sv
module bce_cond_pick
  import bce_pkg::*;
(
  input  logic [PAIRS-1:0]   base_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic               taken_o
);

  logic [SEL_W-2:0] pair_idx;
  logic             pick;

  always_comb begin
    pair_idx = sel_i[SEL_W-1:1];
    pick     = base_i[pair_idx];
    taken_o  = pick ^ sel_i[0];
  end

endmodule

// File: rtl/bce_target_calc.sv
module bce_target_calc #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned LONG_W  = 16
) (
  input  logic              long_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [LONG_W-1:0] off_i,
  output logic [ADDR_W-1:0] target_o
);

  localparam int unsigned SHORT_PAD = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] short_ext;
  logic [ADDR_W-1:0] long_ext;
  logic [ADDR_W-1:0] disp;

  assign short_ext = {{SHORT_PAD{off_i[SHORT_W-1]}}, off_i[SHORT_W-1:0]};

  generate
    if (LONG_W < ADDR_W) begin : g_long_pad
      assign long_ext = {{(ADDR_W-LONG_W){off_i[LONG_W-1]}}, off_i};
    end else begin : g_long_fit
      assign long_ext = off_i[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    disp     = long_i ? long_ext : short_ext;
    target_o = pc_i + disp;
  end

endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import bce_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned LONG_W  = 16
) (
  input  logic [SEL_W-1:0]  cond_sel_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              long_i,
  input  logic [ADDR_W-1:0] pc_next_i,
  input  logic [LONG_W-1:0] offset_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);

  tflags_t          tf;
  logic [PAIRS-1:0] base;
  logic             unused_hi_flags;

  assign tf              = unpack_flags(flags_i);
  assign unused_hi_flags = ^flags_i[FLAG_W-1:POS_N+1];

  bce_pred_vec i_pred (
    .flags_i (tf),
    .base_o  (base)
  );

  bce_cond_pick i_pick (
    .base_i  (base),
    .sel_i   (cond_sel_i),
    .taken_o (taken_o)
  );

  bce_target_calc #(
    .ADDR_W  (ADDR_W),
    .SHORT_W (SHORT_W),
    .LONG_W  (LONG_W)
  ) i_tgt (
    .long_i   (long_i),
    .pc_i     (pc_next_i),
    .off_i    (offset_i),
    .target_o (target_o)
  );

endmodule

// File: rtl/branch_eval_chk.sv
module branch_eval_chk (
  input logic [3:0]  cond_sel_i,
  input logic [7:0]  flags_i,
  input logic        long_i,
  input logic [15:0] pc_next_i,
  input logic [15:0] offset_i,
  input logic        taken_o,
  input logic [15:0] target_o
);

  logic [15:0] delta;
  assign delta = target_o - pc_next_i;

  always_comb begin
    // R2
    if (cond_sel_i == 4'd0) always_taken_chk: assert (taken_o == 1'b1);
    // R2
    if (cond_sel_i == 4'd1) never_taken_chk: assert (taken_o == 1'b0);
    // R4
    if (cond_sel_i == 4'd5) carry_set_chk: assert (taken_o == flags_i[0]);
    // R5
    if (cond_sel_i == 4'd7) equal_chk: assert (taken_o == flags_i[2]);
    // R7
    if (cond_sel_i == 4'd13) signed_lt_chk: assert (taken_o == (flags_i[3] != flags_i[1]));
    // R9
    if (!long_i) short_disp_chk: assert ((delta[7:0] == offset_i[7:0]) &&
                                         (delta[15:8] == (offset_i[7] ? 8'hFF : 8'h00)));
    // R10
    if (long_i) long_disp_chk: assert (delta == offset_i);
  end

endmodule

bind branch_eval branch_eval_chk i_chk (
  .cond_sel_i (cond_sel_i),
  .flags_i    (flags_i),
  .long_i     (long_i),
  .pc_next_i  (pc_next_i),
  .offset_i   (offset_i),
  .taken_o    (taken_o),
  .target_o   (target_o)
);

// File: tb/test_branch_eval.sv
`timescale 1ns/1ps
module test_branch_eval;

  logic        clk;
  logic        rst_n;
  logic [3:0]  sel;
  logic [7:0]  flags;
  logic        lng;
  logic [15:0] pc;
  logic [15:0] off;
  logic        taken;
  logic [15:0] target;

  int checks   = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    logic        tk;
    logic [15:0] tg;
    string       tag;
  } exp_t;

  exp_t sb[$];

  branch_eval i_branch_eval (
    .cond_sel_i (sel),
    .flags_i    (flags),
    .long_i     (lng),
    .pc_next_i  (pc),
    .offset_i   (off),
    .taken_o    (taken),
    .target_o   (target)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic model_taken(input logic [3:0] s, input logic [7:0] f);
    logic n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (s)
      4'd0:  return 1'b1;              // R2 always
      4'd1:  return 1'b0;              // R2 never
      4'd2:  return (c == 0) && (z == 0); // R3
      4'd3:  return (c == 1) || (z == 1); // R3
      4'd4:  return c == 0;            // R4
      4'd5:  return c == 1;            // R4
      4'd6:  return z == 0;            // R5
      4'd7:  return z == 1;            // R5
      4'd8:  return v == 0;            // R6
      4'd9:  return v == 1;            // R6
      4'd10: return n == 0;            // R6
      4'd11: return n == 1;            // R6
      4'd12: return n == v;            // R7
      4'd13: return n != v;            // R7
      4'd14: return (z == 0) && (n == v); // R8
      default: return (z == 1) || (n != v); // R8
    endcase
  endfunction

  function automatic logic [15:0] model_target(input logic l, input logic [15:0] p,
                                               input logic [15:0] o);
    int signed d;
    if (l) d = int'($signed(o));
    else   d = int'($signed(o[7:0]));
    return 16'((int'(p) + d) & 16'hFFFF);
  endfunction

  function automatic string sel_tag(input logic [3:0] s);
    case (s)
      4'd0, 4'd1:   return "R2";
      4'd2, 4'd3:   return "R3";
      4'd4, 4'd5:   return "R4";
      4'd6, 4'd7:   return "R5";
      4'd12, 4'd13: return "R7";
      4'd14, 4'd15: return "R8";
      default:      return "R6";
    endcase
  endfunction

  task automatic drive(input logic [3:0] s, input logic [7:0] f, input logic l,
                       input logic [15:0] p, input logic [15:0] o, input string tag);
    exp_t e;
    @(negedge clk);
    sel = s; flags = f; lng = l; pc = p; off = o;
    e.tk  = model_taken(s, f);
    e.tg  = model_target(l, p, o);
    e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: one scoreboard item per rising edge, half a period after the drive
  always @(posedge clk) begin
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (taken !== e.tk || target !== e.tg) begin
        failures++;
        $display("FAIL %s taken=%0b target=%h expected taken=%0b target=%h",
                 e.tag, taken, target, e.tk, e.tg);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    sel = '0; flags = '0; lng = 1'b0; pc = '0; off = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // idle inputs: always condition, zero displacement (R2)
    drive(4'd0, 8'h00, 1'b0, 16'h0000, 16'h0000, "R2");

    // every selector against every flag nibble, varying offsets and mode
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 16; f++) begin
        drive(4'(s), {4'(~f), 4'(f)}, f[0], 16'(16'h1000 + s * 16'h0111),
              16'(f * 16'h0813 + s), sel_tag(4'(s)));
      end
    end

    // R1: upper flag nibble toggled with fixed low nibble
    for (int h = 0; h < 16; h++) begin
      drive(4'd3, {4'(h), 4'b0000}, 1'b0, 16'h2000, 16'h0004, "R1");
      drive(4'd14, {4'(h), 4'b1010}, 1'b1, 16'h2000, 16'h0100, "R1");
    end

    // R9: short displacement edges, junk in upper byte
    drive(4'd7, 8'h04, 1'b0, 16'h4000, 16'hAB7F, "R9");  // +127
    drive(4'd7, 8'h04, 1'b0, 16'h4000, 16'h5580, "R9");  // -128
    drive(4'd7, 8'h04, 1'b0, 16'h4000, 16'hFFFF, "R9");  // -1
    drive(4'd6, 8'h00, 1'b0, 16'h0005, 16'h00F0, "R9");  // wraps below 0
    drive(4'd6, 8'h00, 1'b0, 16'hFFF0, 16'h0070, "R9");  // wraps past top

    // R10: long displacement edges
    drive(4'd0, 8'h00, 1'b1, 16'h8000, 16'h7FFF, "R10");
    drive(4'd0, 8'h00, 1'b1, 16'h1234, 16'h8000, "R10");
    drive(4'd0, 8'h00, 1'b1, 16'hFFF0, 16'h0020, "R10");
    drive(4'd0, 8'h00, 1'b1, 16'h0010, 16'hFFE0, "R10");

    // R11: never taken, destination still produced, in both modes
    drive(4'd1, 8'hFF, 1'b1, 16'hFFFE, 16'h7FFF, "R11");
    drive(4'd1, 8'h00, 1'b0, 16'h0001, 16'h0080, "R11");
    drive(4'd15, 8'h00, 1'b1, 16'hC000, 16'h4000, "R11");

    while (sb.size() > 0) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule